// File: doc/BRIEF.md
# Serial EEPROM Write-Command Slave

This block is the device-side front end of a three-wire serial EEPROM that understands a single instruction: writing one 16-bit word. A host asserts chip select and shifts a frame in on the data input, one bit per rising edge of the serial clock. The frame is a start bit, a two-bit opcode, an address sent from its most significant bit down, and sixteen data bits sent from bit 15 down to bit 0. The word is committed to an internal word array only when chip select falls right after the last data bit and the program-enable input is high.

The commit starts a self-timed programming interval whose length is a count of system clock cycles. If chip select is raised again while that interval runs, the data output drives 0 (busy). Once it has finished, the data output drives 1 (ready) until the next start bit is seen. The serial pins are synchronized into the system clock domain and their edges are detected there. A parallel lookup port exposes the stored words to the surrounding logic. The address field may be wider than the array: leading address bits beyond the array size are then don't-care.

Top module: `mw_write_slave`

## Requirements
- R1: After reset every word of the array reads 16'hFFFF on `rd_data`, and `do_oe` is 0.
- R2: A frame is start bit 1, opcode bits 0 then 1, FRAME_ADDR_W address bits MSB first, and 16 data bits MSB first. Zeros sent before the start bit are ignored. When chip select falls directly after bit D0 with program-enable high, the word is stored at the address formed by the low MEM_ADDR_W address bits.
- R3: While chip select is low, and while a frame is being shifted in with no programming interval running, `do_oe` is 0.
- R4: After a commit, the block is busy for exactly PROG_CYCLES system clocks. During that time, with chip select high, `do_oe` is 1 and `do_o` is 0.
- R5: After the interval ends, with chip select high, `do_oe` is 1 and `do_o` is 1. The next start bit returns `do_oe` to 0.
- R6: If chip select falls before all 16 data bits have arrived, nothing is stored, no busy interval starts, and status is not driven on the next chip-select assertion.
- R7: A rising serial clock edge after D0 and before chip select falls voids the frame, and nothing is stored.
- R8: A frame whose opcode is not 0,1 stores nothing.
- R9: With program-enable low when chip select falls after a complete frame, nothing is stored and the status reads ready (1) at once.
- R10: Frames sent while the programming interval runs are ignored and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from host |
| di | input | 1 | Serial data in |
| pe | input | 1 | Program enable |
| do_o | output | 1 | Serial data out level (status) |
| do_oe | output | 1 | Output enable for data out; 0 means high impedance |
| rd_addr | input | MEM_ADDR_W | Lookup address into the word array |
| rd_data | output | DATA_W | Word stored at `rd_addr` (combinational) |

## Verification
Every serial pin passes two synchronizer flops. An edge is acted on at the following clock, so a state change lands three system clocks after the pin moves, and the status outputs follow chip select two clocks after it changes. The bench drives pins on falling clock edges, holds each serial clock level for eight system clocks, and samples outputs at least four clocks after the last pin change. Busy is checked a dozen clocks into the interval and ready is checked well past PROG_CYCLES. The exact interval length is measured by a cycle counter in the checker. `rd_data` is combinational, so it is sampled one clock after `rd_addr` is set.

// File: rtl/mw_write_slave.sv
module mw_write_slave #(
  parameter int FRAME_ADDR_W = 6,
  parameter int MEM_ADDR_W   = 6,
  parameter int DATA_W       = 16,
  parameter int PROG_CYCLES  = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs,
  input  logic                  sk,
  input  logic                  di,
  input  logic                  pe,
  output logic                  do_o,
  output logic                  do_oe,
  input  logic [MEM_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     rd_data
);
  localparam int OP_W       = 2;
  localparam int FRAME_BITS = OP_W + FRAME_ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int PCNT_W     = $clog2(PROG_CYCLES + 1);
  localparam int DEPTH      = 1 << MEM_ADDR_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_FULL, ST_VOID} st_t;

  logic [SYNC_STAGES-1:0] cs_sh, sk_sh, di_sh, pe_sh;
  logic cs_s, sk_s, di_s, pe_s, cs_q, sk_q;
  logic cs_fall, sk_rise, opc_ok, wr_en, st_idle;
  st_t st;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0] bit_cnt;
  logic [PCNT_W-1:0] prog_cnt;
  logic busy, rdy_show;
  logic [DATA_W-1:0] mem [DEPTH];

  assign cs_s    = cs_sh[SYNC_STAGES-1];
  assign sk_s    = sk_sh[SYNC_STAGES-1];
  assign di_s    = di_sh[SYNC_STAGES-1];
  assign pe_s    = pe_sh[SYNC_STAGES-1];
  assign cs_fall = cs_q & ~cs_s;
  assign sk_rise = sk_s & ~sk_q;
  assign opc_ok  = shreg[FRAME_BITS-1 -: OP_W] == 2'b01;
  assign wr_en   = cs_fall & (st == ST_FULL) & opc_ok & pe_s;
  assign st_idle = st == ST_IDLE;
  assign do_oe   = cs_s & (busy | rdy_show);
  assign do_o    = do_oe & ~busy;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh <= '0;
      sk_sh <= '0;
      di_sh <= '0;
      pe_sh <= '0;
      cs_q  <= 1'b0;
      sk_q  <= 1'b0;
    end else begin
      cs_sh <= {cs_sh[SYNC_STAGES-2:0], cs};
      sk_sh <= {sk_sh[SYNC_STAGES-2:0], sk};
      di_sh <= {di_sh[SYNC_STAGES-2:0], di};
      pe_sh <= {pe_sh[SYNC_STAGES-2:0], pe};
      cs_q  <= cs_s;
      sk_q  <= sk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      prog_cnt <= '0;
      busy     <= 1'b0;
      rdy_show <= 1'b0;
    end else begin
      if (busy) begin
        if (prog_cnt == '0) busy <= 1'b0;
        else prog_cnt <= prog_cnt - 1'b1;
      end
      if (cs_fall) begin
        st <= ST_IDLE;
        if (st == ST_FULL && opc_ok) begin
          rdy_show <= 1'b1;
          if (pe_s) begin
            busy     <= 1'b1;
            prog_cnt <= PCNT_W'(PROG_CYCLES - 1);
          end
        end
      end else if (cs_s && sk_rise && !busy) begin
        unique case (st)
          ST_IDLE: if (di_s) begin
            st       <= ST_SHIFT;
            bit_cnt  <= '0;
            rdy_show <= 1'b0;
          end
          ST_SHIFT: begin
            shreg <= {shreg[FRAME_BITS-2:0], di_s};
            if (bit_cnt == CNT_W'(FRAME_BITS - 1)) st <= ST_FULL;
            else bit_cnt <= bit_cnt + 1'b1;
          end
          ST_FULL: st <= ST_VOID;
          ST_VOID: st <= ST_VOID;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[shreg[DATA_W +: MEM_ADDR_W]] <= shreg[DATA_W-1:0];
    end
  end
endmodule

module mw_write_slave_chk #(
  parameter int MEM_ADDR_W  = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_s,
  input logic                  pe_s,
  input logic                  cs_fall,
  input logic                  busy,
  input logic                  wr_en,
  input logic                  st_idle,
  input logic                  do_o,
  input logic                  do_oe,
  input logic [MEM_ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0]     rd_data
);
  logic [31:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else run_len <= busy ? run_len + 1 : '0;
  end

  AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) !cs_s |-> !do_oe); // R3
  AST_BUSY_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (busy && cs_s) |-> (do_oe && !do_o)); // R4
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> run_len == PROG_CYCLES); // R4
  AST_ARRAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> (!$stable(rd_addr) || $stable(rd_data))); // R6
  AST_PROG_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> ($past(pe_s) && $past(cs_fall))); // R9
  AST_BUSY_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n) busy |-> st_idle); // R10
endmodule

bind mw_write_slave mw_write_slave_chk #(
  .MEM_ADDR_W(MEM_ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .pe_s(pe_s), .cs_fall(cs_fall),
  .busy(busy), .wr_en(wr_en), .st_idle(st_idle), .do_o(do_o), .do_oe(do_oe),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/mw_write_slave_tb.sv
module mw_write_slave_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int PROG = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, pe = 1'b0;
  logic do_o, do_oe;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [1<<AW];

  always #2.5 clk = ~clk;

  mw_write_slave #(.FRAME_ADDR_W(AW), .MEM_ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .pe(pe),
    .do_o(do_o), .do_oe(do_oe), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    di = b; sk = 1'b0; clks(8);
    sk = 1'b1; clks(8);
    sk = 1'b0;
  endtask

  task automatic send_frame(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int ndata, input int lead0, input bit extra);
    cs = 1'b1; clks(8);
    for (int i = 0; i < lead0; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
    for (int i = DW - 1; i >= DW - ndata; i--) send_bit(d[i]);
    if (extra) send_bit(1'b0);
    clks(8);
  endtask

  task automatic drop_cs();
    cs = 1'b0; clks(10);
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a);
    rd_addr = a; clks(1);
    check(req, rd_data, model[a]);
  endtask

  initial begin
    clks(190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a, b;
    logic [DW-1:0] d;
    logic p;
    for (int i = 0; i < (1 << AW); i++) model[i] = 16'hFFFF;
    void'($urandom(32'h1234_5EED));
    clks(4); rst_n = 1'b1; clks(4);

    check("R1 oe", do_oe, 0);
    for (int i = 0; i < (1 << AW); i += 7) read_chk("R1 erased", AW'(i));

    // R2 / R3 / R4 / R5 directed write with leading zeros
    pe = 1'b1;
    send_frame(2'b01, 6'h2A, 16'hA55A, DW, 2, 1'b0);
    check("R3 shifting", do_oe, 0);
    drop_cs();
    check("R3 cs low", do_oe, 0);
    model[6'h2A] = 16'hA55A;
    cs = 1'b1; clks(6);
    check("R4 oe", do_oe, 1);
    check("R4 busy level", do_o, 0);
    read_chk("R2 stored", 6'h2A);
    clks(PROG + 20);
    check("R5 oe", do_oe, 1);
    check("R5 ready level", do_o, 1);
    send_bit(1'b1); clks(4);
    check("R5 cleared by start", do_oe, 0);
    drop_cs();

    // R6 short frame
    send_frame(2'b01, 6'h05, 16'h1234, 10, 0, 1'b0);
    drop_cs();
    cs = 1'b1; clks(6);
    check("R6 no status", do_oe, 0);
    cs = 1'b0; clks(6);
    read_chk("R6 no write", 6'h05);

    // R7 extra clock after D0
    send_frame(2'b01, 6'h06, 16'h4321, DW, 0, 1'b1);
    drop_cs();
    read_chk("R7 no write", 6'h06);

    // R8 bad opcodes
    send_frame(2'b11, 6'h07, 16'h0F0F, DW, 0, 1'b0); drop_cs();
    send_frame(2'b10, 6'h07, 16'h0F0F, DW, 0, 1'b0); drop_cs();
    send_frame(2'b00, 6'h07, 16'h0F0F, DW, 0, 1'b0); drop_cs();
    read_chk("R8 no write", 6'h07);

    // R9 program enable low
    pe = 1'b0;
    send_frame(2'b01, 6'h08, 16'h00FF, DW, 0, 1'b0);
    drop_cs();
    cs = 1'b1; clks(6);
    check("R9 ready oe", do_oe, 1);
    check("R9 ready level", do_o, 1);
    cs = 1'b0; clks(6);
    read_chk("R9 no write", 6'h08);
    pe = 1'b1;

    // R10 frame during busy
    send_frame(2'b01, 6'h10, 16'hBEEF, DW, 0, 1'b0);
    drop_cs();
    model[6'h10] = 16'hBEEF;
    send_frame(2'b01, 6'h11, 16'hCAFE, DW, 0, 1'b0);
    check("R4 still busy", do_o, 0);
    drop_cs();
    clks(PROG + 20);
    read_chk("R10 ignored", 6'h11);
    read_chk("R2 first kept", 6'h10);

    // random writes
    for (int k = 0; k < 20; k++) begin
      a = AW'($urandom);
      d = DW'($urandom);
      p = ($urandom % 4) != 0;
      pe = p;
      send_frame(2'b01, a, d, DW, int'($urandom % 3), 1'b0);
      drop_cs();
      if (p) model[a] = d;
      clks(PROG + 20);
      read_chk(p ? "R2 random" : "R9 random", a);
      b = AW'($urandom);
      read_chk("R2 other word", b);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule